// File: doc/BRIEF.md
# Chained Watchdog Counter Bank

This block holds four 64-bit down-counters behind a small 32-bit register bus. Each counter has a control word and a 64-bit count, which is read and written as two 32-bit halves. A counter decrements once every P clocks, where P is its programmed prescale value. When it reaches zero it issues a single-cycle end-count pulse. A counter runs either once (one-shot) or in a retrigger mode. In retrigger mode it reloads its programmed start value whenever its chosen trigger fires. The only trigger source is the end-count pulse of the counter just below it.

A 4-bit select register marks which counters act as the system watchdog. When a selected counter ends its count, a sticky reset request is raised and stays high until the block is reset. The intended use chains two counters. The watchdog counter runs in retrigger mode, fed by its lower neighbour, and that neighbour is a one-shot counter holding zero. Software kicks the watchdog by clearing and then setting the neighbour's enable bit. The neighbour fires at once and the watchdog reloads, so it never stops counting during the kick. Reading the low count half captures the high half into a holding register, so a 64-bit value read as two halves is always coherent.

Top module: `wdt_counter_bank`

## Requirements
- R1: After `rst_ni` the following are all zero: every control word, every count half, the select register and `wdt_rst_o`.
- R2: Counter n decodes at byte address n*16. The control word is at +0, the low count half at +4 and the high count half at +8. The select register is at 0x40. Control word fields are: bit 0 enable, bit 1 running flag (read-only, writes ignored), bits 3:2 mode (11 = retrigger, any other code = one-shot), bits 7:4 trigger source, bits 15:8 prescale. Bits 31:16 read as zero.
- R3: Writing a count half loads that half of both the reload value and the live count. The other half is left unchanged.
- R4: A read of the low half captures the live high half at that moment. A later read of the high half returns that captured value.
- R5: A started counter decrements once every P clocks, where P is the prescale value and values 0 and 1 act as 2. A count of N stops N*P clocks after the start edge.
- R6: Enabling a one-shot counter (enable going 0 to 1) whose count is zero gives an end-count pulse on that same edge. The counter does not start running.
- R7: Enabling a one-shot counter with a nonzero count starts it. At zero it emits one end-count pulse, stops, and its running flag clears with the count left at zero.
- R8: In retrigger mode with trigger code 5, a counter reloads its reload value and starts running one clock after the end-count pulse of the counter below it. Enabling it alone does not start it, and any other trigger code never starts it.
- R9: Clearing enable freezes the count and clears the running flag. Enabling a one-shot counter again resumes from the frozen count.
- R10: An end-count on a counter whose select bit is 1 raises `wdt_rst_o` on the next clock. It then stays high, whatever the select register holds, until `rst_ni`.
- R11: An end-count on a counter whose select bit is 0 never raises `wdt_rst_o`.
- R12: Clearing and then setting enable on a zero-count one-shot neighbour reloads a running retrigger counter to its full value. The counter stays running throughout the kick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address of the register |
| we_i | input | 1 | Write strobe, sampled on the clock edge |
| re_i | input | 1 | Read strobe, used to capture the high count half |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| wdt_rst_o | output | 1 | Sticky watchdog reset request |

## Verification
A wrong prescaler phase or a missed decrement shows up as a stop time that is off by a few clocks from N*P. The bench measures this to the exact cycle over a sweep of prescale values and counts. If the retrigger path drops or delays the neighbour pulse, the watchdog counter either never starts or starts a clock late, and that is visible in the running flag one clock after the kick. A stale holding register appears as soon as a high half is read after the count carries across the 32-bit boundary. A lost sticky bit appears as `wdt_rst_o` falling on the clock after it rose.

// File: rtl/wdt_bank_pkg.sv
package wdt_bank_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 64;
  localparam int PRE_W  = 8;

  localparam logic [1:0] MODE_HW   = 2'b11;
  localparam logic [3:0] SRC_PREV  = 4'd5;
  localparam logic [3:0] OFF_CTRL  = 4'h0;
  localparam logic [3:0] OFF_LO    = 4'h4;
  localparam logic [3:0] OFF_HI    = 4'h8;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic [3:0]       src;
    logic [1:0]       mode;
  } cnt_cfg_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         clr_i,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q, div_eff;
  logic         wrap;

  assign div_eff = (div_i < W'(2)) ? W'(2) : div_i;
  assign wrap    = (cnt_q == div_eff - W'(1));
  assign tick_o  = run_i & ~clr_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i || !run_i) cnt_q <= '0;
    else if (wrap)            cnt_q <= '0;
    else                      cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/wdt_cnt_unit.sv
module wdt_cnt_unit
  import wdt_bank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ctrl_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic              rd_lo_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              trig_i,
  output logic [WORD_W-1:0] ctrl_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [WORD_W-1:0] hold_o,
  output logic              end_o
);
  cnt_cfg_t          cfg_q, cfg_n;
  logic              en_q, en_n, act_q, end_q, tick;
  logic [CNT_W-1:0]  cnt_q, init_q;
  logic [WORD_W-1:0] hold_q;
  logic              wr_cnt, hw_n, start_hw, start_os;

  assign cfg_n    = wr_ctrl_i ? cnt_cfg_t'(wdata_i[15:2]) : cfg_q;
  assign en_n     = wr_ctrl_i ? wdata_i[0] : en_q;
  assign wr_cnt   = wr_lo_i | wr_hi_i;
  assign hw_n     = (cfg_n.mode == MODE_HW);
  assign start_hw = en_n & hw_n & trig_i & (cfg_n.src == SRC_PREV) & ~wr_cnt;
  assign start_os = en_n & ~hw_n & ~en_q & ~wr_cnt;

  wdt_prescaler #(.W(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (act_q & en_n),
    .clr_i  (start_hw | start_os),
    .div_i  (cfg_q.pre),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      en_q   <= 1'b0;
      act_q  <= 1'b0;
      end_q  <= 1'b0;
      cnt_q  <= '0;
      init_q <= '0;
      hold_q <= '0;
    end else begin
      end_q <= 1'b0;
      if (rd_lo_i) hold_q <= cnt_q[CNT_W-1:WORD_W];
      if (wr_ctrl_i) begin
        cfg_q <= cfg_n;
        en_q  <= en_n;
      end
      if (wr_lo_i) begin
        cnt_q[WORD_W-1:0]  <= wdata_i;
        init_q[WORD_W-1:0] <= wdata_i;
      end else if (wr_hi_i) begin
        cnt_q[CNT_W-1:WORD_W]  <= wdata_i;
        init_q[CNT_W-1:WORD_W] <= wdata_i;
      end else if (!en_n) begin
        act_q <= 1'b0;
      end else if (start_hw) begin
        cnt_q <= init_q;
        act_q <= 1'b1;
      end else if (start_os) begin
        if (cnt_q == '0) end_q <= 1'b1;
        else             act_q <= 1'b1;
      end else if (act_q && tick) begin
        if (cnt_q < CNT_W'(2)) begin
          cnt_q <= '0;
          end_q <= 1'b1;
          act_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end

  assign ctrl_o = {16'b0, cfg_q, act_q, en_q};
  assign cnt_o  = cnt_q;
  assign hold_o = hold_q;
  assign end_o  = end_q;
endmodule

// File: rtl/wdt_counter_bank.sv
module wdt_counter_bank
  import wdt_bank_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int ADDR_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              wdt_rst_o
);
  localparam int IDX_W = ADDR_W - 4;
  localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(NUM_CNT * 16);

  logic [NUM_CNT-1:0][WORD_W-1:0] ctrl_vec, hold_vec;
  logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_vec;
  logic [NUM_CNT-1:0] end_vec, trig_vec, hit_vec;
  logic [NUM_CNT-1:0] wr_ctrl_v, wr_lo_v, wr_hi_v, rd_lo_v;
  logic [NUM_CNT-1:0] sel_q;
  logic               rst_q;
  logic [3:0]         off;

  assign off = addr_i[3:0];

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
    assign hit_vec[n]   = (addr_i[ADDR_W-1:4] == IDX_W'(n));
    assign wr_ctrl_v[n] = we_i & hit_vec[n] & (off == OFF_CTRL);
    assign wr_lo_v[n]   = we_i & hit_vec[n] & (off == OFF_LO);
    assign wr_hi_v[n]   = we_i & hit_vec[n] & (off == OFF_HI);
    assign rd_lo_v[n]   = re_i & hit_vec[n] & (off == OFF_LO);

    if (n == 0) begin : g_first
      assign trig_vec[n] = 1'b0;
    end else begin : g_chain
      assign trig_vec[n] = end_vec[n-1];
    end

    wdt_cnt_unit u_unit (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_ctrl_i (wr_ctrl_v[n]),
      .wr_lo_i   (wr_lo_v[n]),
      .wr_hi_i   (wr_hi_v[n]),
      .rd_lo_i   (rd_lo_v[n]),
      .wdata_i   (wdata_i),
      .trig_i    (trig_vec[n]),
      .ctrl_o    (ctrl_vec[n]),
      .cnt_o     (cnt_vec[n]),
      .hold_o    (hold_vec[n]),
      .end_o     (end_vec[n])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == SEL_ADDR) rdata_o = WORD_W'(sel_q);
    for (int n = 0; n < NUM_CNT; n++) begin
      if (hit_vec[n]) begin
        case (off)
          OFF_CTRL: rdata_o = ctrl_vec[n];
          OFF_LO:   rdata_o = cnt_vec[n][WORD_W-1:0];
          OFF_HI:   rdata_o = hold_vec[n];
          default:  rdata_o = '0;
        endcase
      end
    end
  end

  // sticky request; only rst_ni clears it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      rst_q <= 1'b0;
    end else begin
      if (we_i && addr_i == SEL_ADDR) sel_q <= wdata_i[NUM_CNT-1:0];
      rst_q <= rst_q | (|(end_vec & sel_q));
    end
  end

  assign wdt_rst_o = rst_q;
endmodule

// File: rtl/wdt_bank_chk.sv
module wdt_bank_chk #(
  parameter int NUM_CNT = 4
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [NUM_CNT-1:0]       end_vec,
  input logic [NUM_CNT-1:0]       sel_q,
  input logic                     wdt_rst_o,
  input logic [NUM_CNT-1:0][31:0] ctrl_vec,
  input logic [NUM_CNT-1:0][63:0] cnt_vec,
  input logic [NUM_CNT-1:0][31:0] hold_vec,
  input logic [NUM_CNT-1:0]       rd_lo_v,
  input logic [NUM_CNT-1:0]       wr_ctrl_v,
  input logic [NUM_CNT-1:0]       wr_lo_v,
  input logic [NUM_CNT-1:0]       wr_hi_v
);
  for (genvar n = 0; n < NUM_CNT; n++) begin : g_chk
    // R7
    end_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      end_vec[n] |=> !end_vec[n]);
    // R7
    stop_on_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      end_vec[n] |-> !ctrl_vec[n][1]);
    // R4
    hold_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_lo_v[n] |=> (hold_vec[n] == $past(cnt_vec[n][63:32])));
    // R9
    freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ctrl_vec[n][0] && !wr_ctrl_v[n] && !wr_lo_v[n] && !wr_hi_v[n]) |=> $stable(cnt_vec[n]));
    // R9
    run_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctrl_vec[n][1] |-> ctrl_vec[n][0]);
  end

  // R10
  fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(end_vec & sel_q)) |=> wdt_rst_o);
  // R10
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> wdt_rst_o);
  // R11
  quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wdt_rst_o && ((end_vec & sel_q) == '0)) |=> !wdt_rst_o);
endmodule

bind wdt_counter_bank wdt_bank_chk #(.NUM_CNT(NUM_CNT)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .end_vec   (end_vec),
  .sel_q     (sel_q),
  .wdt_rst_o (wdt_rst_o),
  .ctrl_vec  (ctrl_vec),
  .cnt_vec   (cnt_vec),
  .hold_vec  (hold_vec),
  .rd_lo_v   (rd_lo_v),
  .wr_ctrl_v (wr_ctrl_v),
  .wr_lo_v   (wr_lo_v),
  .wr_hi_v   (wr_hi_v)
);

// File: tb/tb_wdt_counter_bank.sv
`timescale 1ns/1ps
module tb_wdt_counter_bank;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wdt_rst;
  int vectors = 0, miscompares = 0;

  localparam logic [7:0] SEL = 8'h40;

  always #2 clk = ~clk;

  wdt_counter_bank dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .we_i(we), .re_i(re),
    .wdata_i(wdata), .rdata_o(rdata), .wdt_rst_o(wdt_rst)
  );

  function automatic logic [7:0] ca(int n, int off);
    return 8'(n * 16 + off);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic wr(logic [7:0] a, logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    addr = a; re = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic poll_bit(logic [7:0] a, int b, logic val, output int j);
    addr = a; j = -1;
    for (int k = 0; k < 400; k++) begin
      #1;
      if (rdata[b] === val) j = k;
      @(negedge clk);
      if (j >= 0) break;
    end
  endtask

  task automatic ping();
    wr(ca(1, 0), 32'h0200);
    wr(ca(1, 0), 32'h0201);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int j, j2;
    int plist[6] = '{0, 1, 2, 3, 4, 7};
    int nlist[4] = '{1, 2, 3, 5};
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 wdt_rst", 64'(wdt_rst), 64'h0);
    for (int n = 0; n < 4; n++) begin
      rd(ca(n, 0), v); chk("R1 ctrl", 64'(v), 64'h0);
      rd(ca(n, 4), v); chk("R1 lo", 64'(v), 64'h0);
      rd(ca(n, 8), v); chk("R1 hi", 64'(v), 64'h0);
    end
    rd(SEL, v); chk("R1 sel", 64'(v), 64'h0);

    // R2 field layout, running flag read-only
    wr(ca(2, 0), 32'hFFFF_3A5E);
    rd(ca(2, 0), v); chk("R2 ctrl readback", 64'(v), 64'h3A5C);
    wr(SEL, 32'hA);
    rd(SEL, v); chk("R2 sel readback", 64'(v), 64'hA);
    wr(SEL, 32'h0);

    // R3 half writes
    wr(ca(2, 4), 32'h1111_2222);
    wr(ca(2, 8), 32'h3333_4444);
    rd(ca(2, 4), v); chk("R3 lo", 64'(v), 64'h1111_2222);
    rd(ca(2, 8), v); chk("R3 hi", 64'(v), 64'h3333_4444);
    wr(ca(2, 4), 32'h5555_6666);
    rd(ca(2, 4), v); chk("R3 lo rewrite", 64'(v), 64'h5555_6666);
    rd(ca(2, 8), v); chk("R3 hi kept", 64'(v), 64'h3333_4444);

    // R4 coherent read across carry; count 0x1_0000_0002, prescale 2
    wr(ca(3, 0), 32'h0200);
    wr(ca(3, 4), 32'h2);
    wr(ca(3, 8), 32'h1);
    wr(ca(3, 0), 32'h0201);             // start edge E
    repeat (4) @(negedge clk);          // value N-2
    rd(ca(3, 4), v); chk("R4 lo at boundary", 64'(v), 64'h0);
    repeat (3) @(negedge clk);          // value N-4
    rd(ca(3, 8), v); chk("R4 hi captured", 64'(v), 64'h1);
    rd(ca(3, 4), v); chk("R4 lo after carry", 64'(v), 64'hFFFF_FFFE);
    rd(ca(3, 8), v); chk("R4 hi recaptured", 64'(v), 64'h0);

    // R9 freeze and resume
    wr(ca(3, 0), 32'h0200);
    rd(ca(3, 4), v); chk("R9 frozen lo", 64'(v), 64'hFFFF_FFFD);
    repeat (6) @(negedge clk);
    rd(ca(3, 4), v); chk("R9 still frozen", 64'(v), 64'hFFFF_FFFD);
    rd(ca(3, 0), v); chk("R9 flag clear", 64'(v), 64'h0200);
    wr(ca(3, 0), 32'h0201);
    repeat (6) @(negedge clk);
    rd(ca(3, 4), v); chk("R9 resumed", 64'(v), 64'hFFFF_FFFA);
    wr(ca(3, 0), 32'h0200);

    // R5 / R7 sweep of prescale and count on counter 1, select clear
    foreach (plist[pi]) begin
      foreach (nlist[ni]) begin
        int p = plist[pi];
        int n = nlist[ni];
        int pe = (p < 2) ? 2 : p;
        wr(ca(1, 0), 32'h0);
        wr(ca(1, 4), 32'(n));
        wr(ca(1, 8), 32'h0);
        wr(ca(1, 0), 32'((p << 8) | 1));
        poll_bit(ca(1, 0), 1, 1'b0, j);
        chk("R5 stop time", 64'(j), 64'(n * pe));
        rd(ca(1, 4), v); chk("R7 count at zero", 64'(v), 64'h0);
      end
    end
    chk("R11 no request, select clear", 64'(wdt_rst), 64'h0);

    // R8 retrigger from neighbour; counter 3 selected only
    wr(ca(1, 0), 32'h0200);             // neighbour: one-shot, zero, prescale 2
    wr(SEL, 32'h8);
    wr(ca(2, 0), 32'h025C);
    wr(ca(2, 4), 32'h3);
    wr(ca(2, 8), 32'h0);
    wr(ca(2, 0), 32'h025D);
    repeat (5) @(negedge clk);
    rd(ca(2, 0), v); chk("R8 enable alone idle", 64'(v), 64'h025D);
    wr(ca(3, 0), 32'h024C);
    wr(ca(3, 4), 32'h3);
    wr(ca(3, 8), 32'h0);
    wr(ca(3, 0), 32'h024D);
    wr(ca(1, 0), 32'h0201);             // neighbour fires on edge E
    poll_bit(ca(2, 0), 1, 1'b1, j);
    chk("R8 start delay", 64'(j), 64'h1);
    poll_bit(ca(2, 0), 1, 1'b0, j2);
    chk("R8 run length", 64'(j2), 64'h5);
    rd(ca(3, 0), v); chk("R8 other code ignored", 64'(v), 64'h024D);
    rd(ca(3, 4), v); chk("R8 other code count", 64'(v), 64'h3);
    chk("R11 unselected end", 64'(wdt_rst), 64'h0);

    // R12 kick, R10 expiry
    wr(SEL, 32'h4);
    wr(ca(2, 0), 32'h025C);
    wr(ca(2, 4), 32'd20);
    wr(ca(2, 0), 32'h025D);
    ping();                             // edge E
    repeat (10) @(negedge clk);
    rd(ca(2, 4), v); chk("R5 mid count", 64'(v), 64'd16);
    ping();                             // edge E2
    rd(ca(2, 0), v); chk("R12 running during kick", 64'(v), 64'h025F);
    rd(ca(2, 4), v); chk("R12 reloaded", 64'(v), 64'd20);
    addr = ca(2, 0); j = -1;
    for (int k = 0; k < 100; k++) begin
      #1;
      if (wdt_rst === 1'b1) j = k;
      @(negedge clk);
      if (j >= 0) break;
    end
    chk("R10 request time", 64'(j), 64'd40);
    repeat (20) @(negedge clk);
    chk("R10 sticky", 64'(wdt_rst), 64'h1);
    wr(SEL, 32'h0);
    chk("R10 sticky after select clear", 64'(wdt_rst), 64'h1);

    // R1 again after reset
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 request cleared", 64'(wdt_rst), 64'h0);
    rd(ca(2, 4), v); chk("R1 count cleared", 64'(v), 64'h0);

    // R6 zero one-shot fires on the enable edge
    wr(SEL, 32'h2);
    wr(ca(1, 0), 32'h0201);
    #1 chk("R6 request not yet", 64'(wdt_rst), 64'h0);
    @(negedge clk);
    #1 chk("R6 immediate end", 64'(wdt_rst), 64'h1);
    @(negedge clk);
    rd(ca(1, 0), v); chk("R6 not running", 64'(v), 64'h0201);

    finish_run();
  end
endmodule